// File: doc/BRIEF.md
# JTAG Programming-Mode Entry Sequencer

This block is the host side of a short, fixed JTAG conversation. After a one-cycle start request it drives TCK, TMS and TDI so that a target device ends up in its serial programming mode. It first clears the target's TAP controller with a run of TMS-high clocks. It then moves through Run-Test/Idle once and performs three four-bit scans back to back: an instruction scan loading 0x2, a data scan loading 0x2 and a second instruction scan loading 0xC. Each update state runs straight into the next Select-DR-Scan, so Run-Test/Idle is never visited during the scans.

TCK is derived from the system clock through a programmable divider. The bits the target returns on TDO during every shift are kept in one four-bit capture register per scan, so the caller can inspect them once the run ends. A one-cycle done pulse marks the end, with the target's TAP left in Select-DR-Scan.

Top module: `jtag_pgm_entry`

## Requirements
- R1: While reset is held, and whenever the block is idle, TCK is low, TMS is high, TDI is low, busy and done are low; after reset all three capture registers read zero.
- R2: A start pulse seen while idle raises busy on the next system clock. Each run then produces exactly 33 rising TCK edges.
- R3: Each TCK half period, high or low, lasts div+1 system clock cycles. The first rising edge comes div+1 cycles after busy rises.
- R4: The TMS values presented on the first seven rising TCK edges are 1,1,1,1,1,0,1. Five clocks reset the TAP, one enters Run-Test/Idle and one reaches Select-DR-Scan.
- R5: An instruction scan starts from Select-DR-Scan with TMS 1,0,0 and a data scan with TMS 0,0. The four shift clocks carry TMS 0,0,0,1, followed by 1 into Update and 1 into Select-DR-Scan. Over a whole run, Run-Test/Idle is entered exactly once.
- R6: Shift clock i of a scan carries bit i of its value on TDI (least significant bit first). The instruction register receives 0x2 in the first scan and 0xC in the third, and the data register receives 0x2.
- R7: TMS and TDI change only on a falling TCK edge, or at the start while TCK is low. They never change while TCK is high.
- R8: On each rising TCK edge of a shift clock, TDO is stored as bit i of the capture register of the current scan (cap_ir0, cap_dr, cap_ir1 in scan order). All three capture registers are cleared when a run starts.
- R9: Done is a single-cycle pulse that appears on the same clock edge on which busy falls, 66×(div+1) cycles after the start edge. At that point the TAP is in Select-DR-Scan and TCK is low.
- R10: A start pulse that arrives while busy has no effect. The run keeps its length, its pin sequence and its end time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run the entry sequence |
| div | input | DIV_W (8) | TCK divider; half period is div+1 clocks |
| busy | output | 1 | High while the sequence is running |
| done | output | 1 | One-cycle pulse when the sequence ends |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |
| cap_ir0 | output | 4 | TDO bits captured during the first instruction scan |
| cap_dr | output | 4 | TDO bits captured during the data scan |
| cap_ir1 | output | 4 | TDO bits captured during the second instruction scan |

## Verification
A behavioural TAP model in the bench follows every rising TCK edge and decodes the register values actually loaded. This separates a wrong TMS walk, which yields wrong states or an extra Run-Test/Idle visit, from wrong TDI data or bit order, which yields a wrong updated value. The model returns a different TDO word for each scan, and the words change between runs. A mismatch therefore shows which scan's capture register was swapped, mis-ordered or left uncleared. Divider values 0, 2 and 3 separate a wrong half period from a wrong step count through the total run length. A start pulse in the middle of a run shows whether the script restarts.

// File: rtl/jpe_pkg.sv
package jpe_pkg;
  localparam int SCAN_W     = 4;
  localparam int BIT_W      = $clog2(SCAN_W);
  localparam int RST_PULSES = 5;
  localparam int PRE_LEN    = RST_PULSES + 2;      // resets, idle once, select-DR
  localparam int IR_LEN     = 3 + SCAN_W + 2;      // 1,0,0 / shifts / 1,1
  localparam int DR_LEN     = 2 + SCAN_W + 2;      // 0,0 / shifts / 1,1
  localparam int N_STEPS    = PRE_LEN + 2 * IR_LEN + DR_LEN;
  localparam int STEP_W     = $clog2(N_STEPS + 1);
  localparam int N_SCANS    = 3;

  localparam logic [SCAN_W-1:0] CODE_IR_FIRST  = 4'h2;
  localparam logic [SCAN_W-1:0] CODE_DR        = 4'h2;
  localparam logic [SCAN_W-1:0] CODE_IR_SECOND = 4'hC;

  typedef struct packed {
    logic             tms;
    logic             tdi;
    logic             shift;
    logic [1:0]       scan;
    logic [BIT_W-1:0] bitn;
  } step_t;

  function automatic logic [SCAN_W-1:0] scan_code(input int sc);
    case (sc)
      0:       return CODE_IR_FIRST;
      1:       return CODE_DR;
      default: return CODE_IR_SECOND;
    endcase
  endfunction

  // Pin values for TCK cycle idx of the fixed script.
  function automatic step_t script_step(input int idx);
    step_t            s;
    int               j;
    int               off;
    int               sc;
    logic [SCAN_W-1:0] code;
    s     = '0;
    s.tms = 1'b1;
    if (idx < PRE_LEN) begin
      s.tms = (idx != RST_PULSES);
      return s;
    end
    j = idx - PRE_LEN;
    if (j < IR_LEN) begin
      sc  = 0;
      off = j;
    end else if (j < IR_LEN + DR_LEN) begin
      sc  = 1;
      off = j - IR_LEN + 1;                          // data scan skips select-IR
    end else begin
      sc  = 2;
      off = j - IR_LEN - DR_LEN;
    end
    s.scan = 2'(sc);
    code   = scan_code(sc);
    if (off == 1 || off == 2) begin
      s.tms = 1'b0;
    end else if (off >= 3 && off < 3 + SCAN_W) begin
      s.shift = 1'b1;
      s.bitn  = BIT_W'(off - 3);
      s.tms   = (off == 2 + SCAN_W);
      s.tdi   = code[off-3];
    end
    return s;
  endfunction
endpackage

// File: rtl/jpe_tck_gen.sv
module jpe_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tck,
  output logic             evt_rise,
  output logic             evt_fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick     = run && (cnt_q == div);
  assign evt_rise = tick && !tck;
  assign evt_fall = tick && tck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      tck   <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      tck   <= ~tck;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/jpe_capture.sv
module jpe_capture
  import jpe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic [1:0]       scan,
  input  logic [BIT_W-1:0] bitn,
  input  logic             tdo,
  output logic [SCAN_W-1:0] cap [N_SCANS]
);
  for (genvar g = 0; g < N_SCANS; g++) begin : g_scan
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        cap[g] <= '0;
      end else if (sample && (int'(scan) == g)) begin
        cap[g][bitn] <= tdo;
      end
    end
  end
endmodule

// File: rtl/jtag_pgm_entry.sv
module jtag_pgm_entry
  import jpe_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DIV_W-1:0]  div,
  output logic              busy,
  output logic              done,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo,
  output logic [SCAN_W-1:0] cap_ir0,
  output logic [SCAN_W-1:0] cap_dr,
  output logic [SCAN_W-1:0] cap_ir1
);
  logic              evt_rise;
  logic              evt_fall;
  logic              evt_launch;
  logic              evt_last;
  logic [STEP_W-1:0] step_q;
  step_t             cur_step;
  step_t             nxt_step;
  step_t             first_step;
  logic [SCAN_W-1:0] cap [N_SCANS];

  assign evt_launch = start && !busy;
  assign evt_last   = (int'(step_q) == N_STEPS - 1);
  assign cur_step   = script_step(int'(step_q));
  assign nxt_step   = script_step(int'(step_q) + 1);
  assign first_step = script_step(0);

  jpe_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .div      (div),
    .tck      (tck),
    .evt_rise (evt_rise),
    .evt_fall (evt_fall)
  );

  jpe_capture u_cap (
    .clk    (clk),
    .rst    (rst),
    .clear  (evt_launch),
    .sample (busy && evt_rise && cur_step.shift),
    .scan   (cur_step.scan),
    .bitn   (cur_step.bitn),
    .tdo    (tdo),
    .cap    (cap)
  );

  assign cap_ir0 = cap[0];
  assign cap_dr  = cap[1];
  assign cap_ir1 = cap[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      step_q <= '0;
      tms    <= 1'b1;
      tdi    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (evt_launch) begin
        busy   <= 1'b1;
        step_q <= '0;
        tms    <= first_step.tms;
        tdi    <= first_step.tdi;
      end else if (busy && evt_fall) begin
        if (evt_last) begin
          busy <= 1'b0;
          done <= 1'b1;
          tms  <= 1'b1;
          tdi  <= 1'b0;
        end else begin
          step_q <= step_q + 1'b1;
          tms    <= nxt_step.tms;
          tdi    <= nxt_step.tdi;
        end
      end
    end
  end
endmodule

// File: rtl/jpe_checker.sv
module jpe_checker
  import jpe_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              tck,
  input logic              tms,
  input logic              tdi,
  input logic              evt_fall,
  input logic [STEP_W-1:0] step_q
);
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!tck && tms && !tdi));

  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  assert_pins_hold_R7: assert property (@(posedge clk) disable iff (rst)
    tck |-> ($stable(tms) && $stable(tdi)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !evt_fall) |=> $stable(step_q));
endmodule

bind jtag_pgm_entry jpe_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .tck      (tck),
  .tms      (tms),
  .tdi      (tdi),
  .evt_fall (evt_fall),
  .step_q   (step_q)
);

// File: tb/sim_jtag_pgm_entry.sv
module sim_jtag_pgm_entry;
  localparam int TAP_TLR = 0,  TAP_RTI = 1,  TAP_SDR = 2,  TAP_CDR = 3;
  localparam int TAP_SHDR = 4, TAP_E1DR = 5, TAP_PDR = 6,  TAP_E2DR = 7;
  localparam int TAP_UDR = 8,  TAP_SIR = 9,  TAP_CIR = 10, TAP_SHIR = 11;
  localparam int TAP_E1IR = 12, TAP_PIR = 13, TAP_E2IR = 14, TAP_UIR = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] div = 8'd0;
  logic       busy, done, tck, tms, tdi;
  logic       tdo = 1'b0;
  logic [3:0] cap_ir0, cap_dr, cap_ir1;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  jtag_pgm_entry u0 (
    .clk(clk), .rst(rst), .start(start), .div(div), .busy(busy), .done(done),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .cap_ir0(cap_ir0), .cap_dr(cap_dr), .cap_ir1(cap_ir1)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int tap_next(input int s, input logic m);
    case (s)
      TAP_TLR:  return m ? TAP_TLR  : TAP_RTI;
      TAP_RTI:  return m ? TAP_SDR  : TAP_RTI;
      TAP_SDR:  return m ? TAP_SIR  : TAP_CDR;
      TAP_CDR:  return m ? TAP_E1DR : TAP_SHDR;
      TAP_SHDR: return m ? TAP_E1DR : TAP_SHDR;
      TAP_E1DR: return m ? TAP_UDR  : TAP_PDR;
      TAP_PDR:  return m ? TAP_E2DR : TAP_PDR;
      TAP_E2DR: return m ? TAP_UDR  : TAP_SHDR;
      TAP_UDR:  return m ? TAP_SDR  : TAP_RTI;
      TAP_SIR:  return m ? TAP_TLR  : TAP_CIR;
      TAP_CIR:  return m ? TAP_E1IR : TAP_SHIR;
      TAP_SHIR: return m ? TAP_E1IR : TAP_SHIR;
      TAP_E1IR: return m ? TAP_UIR  : TAP_PIR;
      TAP_PIR:  return m ? TAP_E2IR : TAP_PIR;
      TAP_E2IR: return m ? TAP_UIR  : TAP_SHIR;
      default:  return m ? TAP_SDR  : TAP_RTI;
    endcase
  endfunction

  // Behavioural target: TAP state, shift-in, shift-out.
  int         tap_st = TAP_SDR;
  int         rises = 0;
  int         rti_hits = 0;
  int         cap_idx = 0;
  int         ir_n = 0;
  int         dr_n = 0;
  logic [3:0] in_sr = '0;
  logic [3:0] out_sr = '0;
  logic [3:0] ir_upd [2];
  logic [3:0] dr_upd = '0;
  logic [3:0] pat [3];
  logic [63:0] tms_hist = '0;

  always @(posedge tck) begin
    if (rises < 64) tms_hist[rises] = tms;
    rises++;
    if (tap_st == TAP_SHIR || tap_st == TAP_SHDR) begin
      in_sr  = {tdi, in_sr[3:1]};
      out_sr = {1'b0, out_sr[3:1]};
    end
    if (tap_st == TAP_CIR || tap_st == TAP_CDR) begin
      out_sr = (cap_idx < 3) ? pat[cap_idx] : 4'h0;
      cap_idx++;
    end
    tap_st = tap_next(tap_st, tms);
    if (tap_st == TAP_RTI) rti_hits++;
    if (tap_st == TAP_UIR && ir_n < 2) begin
      ir_upd[ir_n] = in_sr;
      ir_n++;
    end
    if (tap_st == TAP_UDR) begin
      dr_upd = in_sr;
      dr_n++;
    end
  end

  always @(negedge tck) tdo = out_sr[0];

  // Half-period and pin-stability monitor, sampled between edges.
  int   hp_len = 0;
  int   hp_bad = 0;
  int   hold_bad = 0;
  logic last_tck = 1'b0;
  logic last_tms = 1'b1;
  logic last_tdi = 1'b0;
  always @(negedge clk) begin
    if (busy) begin
      if (tck == last_tck) begin
        hp_len++;
      end else begin
        if (hp_len != int'(div) + 1) hp_bad++;
        hp_len = 1;
      end
      if (tck && last_tck && (tms != last_tms || tdi != last_tdi)) hold_bad++;
    end else begin
      hp_len = 0;
    end
    last_tck = tck;
    last_tms = tms;
    last_tdi = tdi;
  end

  task automatic run_entry(input logic [7:0] d, input logic [3:0] p0,
                           input logic [3:0] p1, input logic [3:0] p2,
                           input bit poke_start, input bit check_clear);
    string exp_tms;
    int    k;
    int    expect_len;
    bit    seq_ok;
    bit    first_ok;
    div = d;
    pat[0] = p0; pat[1] = p1; pat[2] = p2;
    rises = 0; rti_hits = 0; cap_idx = 0; ir_n = 0; dr_n = 0;
    tms_hist = '0; hp_bad = 0; hold_bad = 0;
    ir_upd[0] = 4'h0; ir_upd[1] = 4'h0; dr_upd = 4'h0;
    expect_len = 66 * (int'(d) + 1);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (check_clear)
      chk({cap_ir0, cap_dr, cap_ir1} == 12'h0, "R8", "captures cleared at start",
          {cap_ir0, cap_dr, cap_ir1}, 0);
    k = 0;
    while (!done && k < 100000) begin
      if (poke_start && k == 40) start = 1'b1;
      if (poke_start && k == 41) start = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(k == expect_len, poke_start ? "R10" : "R9", "cycles start to done", k, expect_len);
    chk(!busy && !tck, "R9", "busy/tck low at done", {busy, tck}, 0);
    chk(rises == 33, "R2", "rising TCK edges", rises, 33);
    chk(hp_bad == 0, "R3", "half periods not div+1", hp_bad, 0);
    chk(hold_bad == 0, "R7", "TMS/TDI moved while TCK high", hold_bad, 0);
    exp_tms = {"1111101", "100000111", "00000111", "100000111"};
    seq_ok = 1'b1;
    first_ok = 1'b1;
    for (int i = 0; i < 33; i++) begin
      if (tms_hist[i] != (exp_tms[i] == "1")) begin
        seq_ok = 1'b0;
        if (i < 7) first_ok = 1'b0;
      end
    end
    chk(first_ok, "R4", "TMS reset/idle preamble", int'(tms_hist[6:0]), 'h5f);
    chk(seq_ok, "R5", "TMS walk over whole run", int'(tms_hist[32:0]), 0);
    chk(rti_hits == 1, "R5", "Run-Test/Idle entries", rti_hits, 1);
    chk(tap_st == TAP_SDR, "R9", "final TAP state", tap_st, TAP_SDR);
    chk(ir_n == 2 && ir_upd[0] == 4'h2, "R6", "first IR value", ir_upd[0], 2);
    chk(dr_n == 1 && dr_upd == 4'h2, "R6", "DR value", dr_upd, 2);
    chk(ir_upd[1] == 4'hC, "R6", "second IR value", ir_upd[1], 'hC);
    chk(cap_ir0 == p0, "R8", "cap_ir0", cap_ir0, p0);
    chk(cap_dr == p1, "R8", "cap_dr", cap_dr, p1);
    chk(cap_ir1 == p2, "R8", "cap_ir1", cap_ir1, p2);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done lasts one cycle", done, 0);
    chk(tms && !tdi && !tck, "R1", "idle pins after run", {tck, tms, tdi}, 2);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk({tck, tms, tdi, busy, done} == 5'b01000, "R1", "pins during reset",
        {tck, tms, tdi, busy, done}, 'h8);
    rst = 1'b0;
    @(negedge clk);
    chk({cap_ir0, cap_dr, cap_ir1} == 12'h0, "R1", "captures after reset",
        {cap_ir0, cap_dr, cap_ir1}, 0);
    chk({tck, tms, tdi, busy, done} == 5'b01000, "R1", "idle after reset",
        {tck, tms, tdi, busy, done}, 'h8);
  endtask

  bit finished = 1'b0;

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    ir_upd[0] = '0; ir_upd[1] = '0;
    pat[0] = '0; pat[1] = '0; pat[2] = '0;
    test_reset();
    run_entry(8'd0, 4'h5, 4'h9, 4'hE, 1'b0, 1'b0);   // fastest TCK
    run_entry(8'd3, 4'h3, 4'hC, 4'h6, 1'b0, 1'b1);   // slower TCK, new TDO words
    run_entry(8'd2, 4'hA, 4'h1, 4'h7, 1'b1, 1'b1);   // start poked mid-run
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule